// File: doc/BRIEF.md
# Down-Counting Event Timer

A single-channel countdown timer for generating timed interrupts. Software sets it up over a plain register bus. The bus has one-cycle write and read strobes, a word address, write data and read data that is registered. Software writes a start count into a pair of load words, picks single-shot or repeating operation, picks a 32-bit or 64-bit counter, and then sets the run bit. The counter counts down once per clock. The cycle in which it holds zero is the expiry cycle. At expiry the timer either reloads and keeps running, or parks at zero. Each expiry sets a pending flag. That flag is gated by an interrupt enable and drives the `irq` output.

Software can read the live count directly. It can also read the count through a snapshot pair. Reading the low live word captures the whole 64-bit count into the snapshot, so software gets a consistent value even when a borrow crosses the word boundary between two reads.

The counter is built around a three-state sequencer:

- **IDLE**: stopped.
- **RUN**: counting.
- **HALT**: single-shot run has expired and the counter is parked at zero.

Its transitions are:

- **start**: IDLE to RUN, when the run bit goes from 0 to 1.
- **stop**: RUN or HALT to IDLE, when the run bit is written 0.
- **park**: RUN to HALT, at expiry in single-shot mode.
- **wrap**: RUN to RUN, at expiry in repeating mode, with a reload.

Top module: `evt_timer`

## Requirements
- R1: After reset, every one of the eight word locations reads 0 and `irq` is 0. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R2: The word locations are:

  | Word | Location |
  |------|----------|
  | 0 | load low |
  | 1 | load high |
  | 2 | live low |
  | 3 | live high |
  | 4 | control |
  | 5 | interrupt |
  | 6 | snapshot low |
  | 7 | snapshot high |

  The two load words read back as written. Control reads back only three bits: bit 0 (repeat), bit 1 (run) and bit 16 (wide). All other control bits read 0.
- R3: The counter is loaded only when a control write changes the run bit from 0 to 1. The loaded value depends on the wide bit of that same write:
  - wide = 1: high and low load words together.
  - wide = 0: the low load word, with the upper half zero.

  A control write with run = 1 while the timer is already running does not reload the counter.
- R4: While running, the count drops by one on every clock. With a load of N, the count reads N in the first cycle after the start write. `irq` (when enabled) is first seen N+1 clocks after the start edge.
- R5: In repeating mode (bit 0 = 1), the counter reloads from the current load words at each expiry and keeps running, so expiries come every N+1 clocks.
- R6: In single-shot mode (bit 0 = 0), the counter parks at zero after its expiry. It raises no further expiry until software writes run = 0 and then run = 1.
- R7: A control write with run = 0 stops the counter and holds the count at its current value. If that write lands in the expiry cycle, the expiry is suppressed.
- R8: Each expiry sets the raw pending flag (interrupt bit 1), whether or not interrupts are enabled. Interrupt bit 2 reads raw AND enable (bit 0). `irq` equals that gated value.
- R9: Writing interrupt bit 3 = 1 clears the raw flag. In the same write, bit 0 sets the enable. Bit 3 always reads 0. If the clear lands in an expiry cycle, the flag stays set.
- R10: The live words 2 and 3 return the count held in the cycle of the read strobe.
- R11: A read of word 2 copies the full 64-bit count into the snapshot pair. Words 6 and 7 return that copy.
- R12: Writes to words 2, 3, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Word address (byte offset divided by four) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Gated interrupt level |

## Verification
The countdown is tried with these patterns:
- A short single-shot load. It pins the expiry latency at N+1 and shows the counter parking.
- A short repeating load. It shows the wrap period, and that a clear landing on an expiry edge does not lose the event.
- A long load with a redundant run write. It separates an edge-triggered start from a level-triggered one.
- A 64-bit load one above a word boundary. It tells the live words, which tear, from the snapshot pair, which does not.
- A stop write placed exactly on the expiry cycle. It separates stop-wins from expire-wins.

A behavioural model in the bench shadows every register and is compared with `irq` and `bus_rdata` on every clock.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_t;

    // Word indexes on the register bus
    localparam int IDX_LOAD_LO = 0;
    localparam int IDX_LOAD_HI = 1;
    localparam int IDX_LIVE_LO = 2;
    localparam int IDX_LIVE_HI = 3;
    localparam int IDX_CTRL    = 4;
    localparam int IDX_INT     = 5;
    localparam int IDX_SNAP_LO = 6;
    localparam int IDX_SNAP_HI = 7;

    // Control word bit positions
    localparam int CTL_REPEAT_BIT = 0;
    localparam int CTL_RUN_BIT    = 1;
    localparam int CTL_WIDE_BIT   = 16;

    // Interrupt word bit positions
    localparam int INT_EN_BIT  = 0;
    localparam int INT_RAW_BIT = 1;
    localparam int INT_GATE_BIT = 2;
    localparam int INT_CLR_BIT = 3;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  expire,
    output logic [DATA_W-1:0]     load_lo,
    output logic [DATA_W-1:0]     load_hi,
    output logic                  repeat_q,
    output logic                  run_q,
    output logic                  wide_q,
    output logic                  ie_q,
    output logic                  raw_q,
    output logic                  arm,
    output logic                  stop,
    output logic [2*DATA_W-1:0]   load_val
);

    localparam logic [ADDR_W-1:0] A_LOAD_LO = ADDR_W'(IDX_LOAD_LO);
    localparam logic [ADDR_W-1:0] A_LOAD_HI = ADDR_W'(IDX_LOAD_HI);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_INT     = ADDR_W'(IDX_INT);

    logic wr_ctrl;
    logic wr_int;
    logic eff_wide;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_int  = bus_wr && (bus_addr == A_INT);

    // Start only on a 0 -> 1 change of the run bit; stop on any run = 0 write
    assign arm  = wr_ctrl && bus_wdata[CTL_RUN_BIT] && !run_q;
    assign stop = wr_ctrl && !bus_wdata[CTL_RUN_BIT];

    // The width written together with the run bit applies to that start
    assign eff_wide = wr_ctrl ? bus_wdata[CTL_WIDE_BIT] : wide_q;
    assign load_val = eff_wide ? {load_hi, load_lo} : {{DATA_W{1'b0}}, load_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_lo  <= '0;
            load_hi  <= '0;
            repeat_q <= 1'b0;
            run_q    <= 1'b0;
            wide_q   <= 1'b0;
            ie_q     <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_LOAD_LO: load_lo <= bus_wdata;
                A_LOAD_HI: load_hi <= bus_wdata;
                A_CTRL: begin
                    repeat_q <= bus_wdata[CTL_REPEAT_BIT];
                    run_q    <= bus_wdata[CTL_RUN_BIT];
                    wide_q   <= bus_wdata[CTL_WIDE_BIT];
                end
                A_INT: ie_q <= bus_wdata[INT_EN_BIT];
                default: ;
            endcase
        end
    end

    // Pending flag: a new expiry outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (expire) begin
            raw_q <= 1'b1;
        end else if (wr_int && bus_wdata[INT_CLR_BIT]) begin
            raw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             stop,
    input  logic             periodic,
    input  logic [CNT_W-1:0] load_val,
    output run_state_t       state,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    run_state_t       state_nxt;
    logic [CNT_W-1:0] count_nxt;
    logic             at_zero;

    assign at_zero = (count == '0);

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (arm) state_nxt = ST_RUN;                 // start
            ST_RUN: begin
                if (stop)                       state_nxt = ST_IDLE; // stop
                else if (at_zero && !periodic)  state_nxt = ST_HALT; // park
                else                            state_nxt = ST_RUN;  // count or wrap
            end
            ST_HALT: if (stop) state_nxt = ST_IDLE;               // stop
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Outputs: expiry pulse and counter update
    always_comb begin
        expire    = 1'b0;
        count_nxt = count;
        unique case (state)
            ST_IDLE: if (arm) count_nxt = load_val;
            ST_RUN: begin
                if (!stop) begin
                    if (at_zero) begin
                        expire = 1'b1;
                        if (periodic) count_nxt = load_val;
                    end else begin
                        count_nxt = count - 1'b1;
                    end
                end
            end
            ST_HALT: count_nxt = count;
            default: count_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end

endmodule

// File: rtl/evt_timer_rdpath.sv
module evt_timer_rdpath
    import evt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*DATA_W-1:0] count,
    input  logic [DATA_W-1:0]   load_lo,
    input  logic [DATA_W-1:0]   load_hi,
    input  logic                repeat_q,
    input  logic                run_q,
    input  logic                wide_q,
    input  logic                ie_q,
    input  logic                raw_q,
    output logic [DATA_W-1:0]   bus_rdata
);

    localparam int NWORD = 2;
    localparam logic [ADDR_W-1:0] A_LOAD_LO = ADDR_W'(IDX_LOAD_LO);
    localparam logic [ADDR_W-1:0] A_LOAD_HI = ADDR_W'(IDX_LOAD_HI);
    localparam logic [ADDR_W-1:0] A_LIVE_LO = ADDR_W'(IDX_LIVE_LO);
    localparam logic [ADDR_W-1:0] A_LIVE_HI = ADDR_W'(IDX_LIVE_HI);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_INT     = ADDR_W'(IDX_INT);
    localparam logic [ADDR_W-1:0] A_SNAP_LO = ADDR_W'(IDX_SNAP_LO);
    localparam logic [ADDR_W-1:0] A_SNAP_HI = ADDR_W'(IDX_SNAP_HI);

    logic [DATA_W-1:0] snap [NWORD];
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] int_word;
    logic [DATA_W-1:0] rd_mux;
    logic              snap_take;

    assign snap_take = bus_rd && (bus_addr == A_LIVE_LO);

    // One snapshot register per count word, all captured together
    for (genvar g = 0; g < NWORD; g++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n)         snap[g] <= '0;
            else if (snap_take) snap[g] <= count[g*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTL_REPEAT_BIT] = repeat_q;
        ctrl_word[CTL_RUN_BIT]    = run_q;
        ctrl_word[CTL_WIDE_BIT]   = wide_q;
        int_word = '0;
        int_word[INT_EN_BIT]   = ie_q;
        int_word[INT_RAW_BIT]  = raw_q;
        int_word[INT_GATE_BIT] = raw_q & ie_q;
    end

    always_comb begin
        case (bus_addr)
            A_LOAD_LO: rd_mux = load_lo;
            A_LOAD_HI: rd_mux = load_hi;
            A_LIVE_LO: rd_mux = count[DATA_W-1:0];
            A_LIVE_HI: rd_mux = count[2*DATA_W-1:DATA_W];
            A_CTRL:    rd_mux = ctrl_word;
            A_INT:     rd_mux = int_word;
            A_SNAP_LO: rd_mux = snap[0];
            A_SNAP_HI: rd_mux = snap[1];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic [DATA_W-1:0] load_lo;
    logic [DATA_W-1:0] load_hi;
    logic              repeat_q;
    logic              run_q;
    logic              wide_q;
    logic              ie_q;
    logic              raw_q;
    logic              arm;
    logic              stop;
    logic [CNT_W-1:0]  load_val;
    run_state_t        core_state;
    logic [CNT_W-1:0]  core_count;
    logic              core_expire;

    evt_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (core_expire),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .repeat_q  (repeat_q),
        .run_q     (run_q),
        .wide_q    (wide_q),
        .ie_q      (ie_q),
        .raw_q     (raw_q),
        .arm       (arm),
        .stop      (stop),
        .load_val  (load_val)
    );

    evt_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .stop     (stop),
        .periodic (repeat_q),
        .load_val (load_val),
        .state    (core_state),
        .count    (core_count),
        .expire   (core_expire)
    );

    evt_timer_rdpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .count     (core_count),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .repeat_q  (repeat_q),
        .run_q     (run_q),
        .wide_q    (wide_q),
        .ie_q      (ie_q),
        .raw_q     (raw_q),
        .bus_rdata (bus_rdata)
    );

    assign irq = raw_q & ie_q;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input run_state_t          core_state,
    input logic [2*DATA_W-1:0] core_count,
    input logic                core_expire,
    input logic                arm,
    input logic                stop,
    input logic                run_q,
    input logic                raw_q,
    input logic                repeat_q,
    input logic [2*DATA_W-1:0] load_val
);

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (core_state == ST_RUN && core_count == $past(load_val)));

    // R3
    run_bit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == ST_IDLE) == !run_q);

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == ST_RUN && !stop && core_count != '0)
            |=> (core_count == $past(core_count) - 1'b1));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_expire && repeat_q && !arm)
            |=> (core_state == ST_RUN && core_count == $past(load_val)));

    // R6
    parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == ST_HALT) |-> (!core_expire && core_count == '0));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (core_state == ST_IDLE && $stable(core_count)));

    // R8
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_expire |=> raw_q);

endmodule

bind evt_timer evt_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_state  (core_state),
    .core_count  (core_count),
    .core_expire (core_expire),
    .arm         (arm),
    .stop        (stop),
    .run_q       (run_q),
    .raw_q       (raw_q),
    .repeat_q    (repeat_q),
    .load_val    (load_val)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit live_cmp = 1'b0;

    always #5 clk = ~clk;

    evt_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    // Behavioural model
    longint unsigned m_cnt, m_snap;
    logic [31:0] m_lo, m_hi, m_rdata;
    bit m_rep, m_run, m_wide, m_ie, m_raw;
    int m_mode; // 0 stopped, 1 counting, 2 parked

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_lo;
            3'd1: return m_hi;
            3'd2: return m_cnt[31:0];
            3'd3: return m_cnt[63:32];
            3'd4: return {15'd0, m_wide, 14'd0, m_run, m_rep};
            3'd5: return {29'd0, m_raw & m_ie, m_raw, m_ie};
            3'd6: return m_snap[31:0];
            default: return m_snap[63:32];
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit go, halt, fire, wide_now;
        longint unsigned ld;
        if (!rst_n) begin
            m_cnt = 0; m_snap = 0; m_lo = 0; m_hi = 0; m_rdata = 0;
            m_rep = 0; m_run = 0; m_wide = 0; m_ie = 0; m_raw = 0; m_mode = 0;
        end else begin
            if (rd) begin
                m_rdata = m_read(addr);
                if (addr == 3'd2) m_snap = m_cnt;
            end
            go = wr && addr == 3'd4 && wdata[1] && !m_run;
            halt = wr && addr == 3'd4 && !wdata[1];
            wide_now = (wr && addr == 3'd4) ? wdata[16] : m_wide;
            ld = wide_now ? {m_hi, m_lo} : {32'd0, m_lo};
            fire = 0;
            if (m_mode == 0) begin
                if (go) begin m_mode = 1; m_cnt = ld; end
            end else if (m_mode == 1) begin
                if (halt) m_mode = 0;
                else if (m_cnt == 0) begin
                    fire = 1;
                    if (m_rep) m_cnt = ld; else m_mode = 2;
                end else m_cnt = m_cnt - 1;
            end else if (halt) m_mode = 0;
            if (wr) begin
                case (addr)
                    3'd0: m_lo = wdata;
                    3'd1: m_hi = wdata;
                    3'd4: begin m_rep = wdata[0]; m_run = wdata[1]; m_wide = wdata[16]; end
                    3'd5: begin m_ie = wdata[0]; if (wdata[3]) m_raw = 0; end
                    default: ;
                endcase
            end
            if (fire) m_raw = 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && live_cmp && !done) begin
            chk("R8 irq vs model", 64'(irq), 64'(m_raw & m_ie));
            chk("R10 rdata vs model", 64'(rdata), 64'(m_rdata));
        end
    end

    // Bus tasks: enter and leave on a falling edge
    task automatic wr_w(input logic [2:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        chk(tag, 64'(rdata), 64'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (!irq && k < 60) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live_cmp = 1'b1;

        // R1: reset state
        chk("R1 irq after reset", 64'(irq), 64'd0);
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'd0, "R1 reset read");

        // R12: read-only words ignore writes
        wr_w(3'd2, 32'hAAAA_5555);
        wr_w(3'd3, 32'h1234_0000);
        wr_w(3'd6, 32'hFFFF_FFFF);
        wr_w(3'd7, 32'h0F0F_0F0F);
        rd_chk(3'd2, 32'd0, "R12 live lo");
        rd_chk(3'd3, 32'd0, "R12 live hi");
        rd_chk(3'd6, 32'd0, "R12 snap lo");
        rd_chk(3'd7, 32'd0, "R12 snap hi");

        // R2: readback
        wr_w(3'd0, 32'hDEAD_BEEF);
        wr_w(3'd1, 32'h1234_5678);
        rd_chk(3'd0, 32'hDEAD_BEEF, "R2 load lo");
        rd_chk(3'd1, 32'h1234_5678, "R2 load hi");
        wr_w(3'd4, 32'h0001_0001);
        rd_chk(3'd4, 32'h0001_0001, "R2 ctrl repeat+wide");
        wr_w(3'd4, 32'hFFFF_FFFC);
        rd_chk(3'd4, 32'h0001_0000, "R2 ctrl unused bits");
        wr_w(3'd4, 32'd0);

        // R4 / R6 / R3: single-shot, 32-bit, load 5
        wr_w(3'd5, 32'h9);
        wr_w(3'd0, 32'd5);
        wr_w(3'd1, 32'd7);
        wr_w(3'd4, 32'h2);
        wait_irq(k);
        chk("R4 expiry latency N+1", 64'(k), 64'd6);
        rd_chk(3'd2, 32'd0, "R6 parked at zero");
        rd_chk(3'd3, 32'd0, "R3 high ignored in 32-bit");
        idle(20);
        wr_w(3'd5, 32'h9);
        idle(20);
        rd_chk(3'd5, 32'h1, "R6 no second expiry");
        chk("R6 irq stays low", 64'(irq), 64'd0);
        wr_w(3'd4, 32'd0);
        wr_w(3'd4, 32'h2);
        wait_irq(k);
        chk("R6 rearm latency", 64'(k), 64'd6);
        wr_w(3'd4, 32'd0);
        wr_w(3'd5, 32'h9);

        // R4 / R3: step and no restart
        wr_w(3'd0, 32'd100);
        wr_w(3'd4, 32'h2);
        rd_chk(3'd2, 32'd100, "R4 first count");
        rd_chk(3'd2, 32'd99, "R4 step by one");
        idle(8);
        wr_w(3'd4, 32'h2);
        rd_chk(3'd2, 32'd89, "R3 run rewrite no reload");
        wr_w(3'd4, 32'd0);

        // R5: repeating, load 3
        wr_w(3'd5, 32'h9);
        wr_w(3'd0, 32'd3);
        wr_w(3'd4, 32'h3);
        idle(4);
        chk("R5 first expiry", 64'(irq), 64'd1);
        wr_w(3'd5, 32'h9);
        chk("R5 cleared", 64'(irq), 64'd0);
        idle(2);
        chk("R5 before wrap", 64'(irq), 64'd0);
        idle(1);
        chk("R5 second expiry", 64'(irq), 64'd1);
        wr_w(3'd5, 32'h9);
        wr_w(3'd0, 32'd6);
        idle(30);
        wr_w(3'd4, 32'd0);

        // R9: clear colliding with expiry
        wr_w(3'd0, 32'd3);
        wr_w(3'd4, 32'h3);
        idle(7);
        wr_w(3'd5, 32'h9);
        rd_chk(3'd5, 32'h7, "R9 expiry beats clear");
        wr_w(3'd4, 32'd0);
        wr_w(3'd5, 32'h9);
        rd_chk(3'd5, 32'h1, "R9 clear keeps enable");

        // R7: stop on the expiry cycle
        wr_w(3'd4, 32'h2);
        idle(3);
        wr_w(3'd4, 32'd0);
        rd_chk(3'd5, 32'h1, "R7 expiry suppressed");
        rd_chk(3'd2, 32'd0, "R7 count held at zero");

        // R7: hold on stop
        wr_w(3'd0, 32'd1000);
        wr_w(3'd4, 32'h2);
        idle(5);
        wr_w(3'd4, 32'd0);
        rd_chk(3'd2, 32'd995, "R7 held count");
        idle(5);
        rd_chk(3'd2, 32'd995, "R7 still held");

        // R8: raw without enable
        wr_w(3'd5, 32'h8);
        wr_w(3'd0, 32'd2);
        wr_w(3'd4, 32'h2);
        idle(10);
        rd_chk(3'd5, 32'h2, "R8 raw without enable");
        chk("R8 irq gated", 64'(irq), 64'd0);
        wr_w(3'd5, 32'h1);
        chk("R8 irq on enable", 64'(irq), 64'd1);
        rd_chk(3'd5, 32'h7, "R8 gated bit");
        wr_w(3'd4, 32'd0);
        wr_w(3'd5, 32'h9);

        // R3 / R10 / R11: 64-bit across the word boundary
        wr_w(3'd0, 32'd1);
        wr_w(3'd1, 32'd1);
        wr_w(3'd4, 32'h0001_0002);
        rd_chk(3'd2, 32'd1, "R10 live lo");
        rd_chk(3'd7, 32'd1, "R11 snap hi");
        rd_chk(3'd6, 32'd1, "R11 snap lo");
        rd_chk(3'd3, 32'd0, "R10 live hi after borrow");
        rd_chk(3'd2, 32'hFFFF_FFFD, "R3 wide load low word");
        wr_w(3'd4, 32'd0);

        idle(3);
        finish_run();
    end

endmodule